// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Monitor

This block is the comparison stage of a clocked, all-digital phase-locked loop. It takes a master reference clock and a divided feedback clock, both sampled by a fast system clock. It first halves the reference. It then compares the rising edges of the halved reference with the rising edges of the feedback signal, and produces an `up` pulse when the reference leads and a `dn` pulse when the feedback leads. A pair of set-only flip-flops with a shared clear gives both outputs a one-cycle residual pulse when the inputs are aligned. Downstream logic turns these pulses into a loop correction.

A lock monitor measures how many system cycles the OR of `up` and `dn` is high during each period of the halved reference. It compares that width with a threshold set at run time. The monitor declares lock after 16 consecutive periods within the threshold, and drops lock on the first period that exceeds it. A companion loop reports its own lock state on an input. The block combines the two into one registered unlock flag.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is high, at the next clock edge `up`, `dn` and `locked` go to 0 and `unlock_any` goes to 1.
- R2: `up` starts a new pulse only on every second rising edge of `ref_in`, the first one after reset included. So one `up` pulse occurs per 16 cycles when `ref_in` has an 8-cycle period.
- R3: When the rising edges of `fb_in` and of the halved reference reach the comparator in the same cycle, `up` and `dn` are each high for exactly one cycle per period.
- R4: When the feedback edge lags the reference edge by k cycles (k from 1 to 7 with a 16-cycle period), `up` is high for k+1 cycles and `dn` for 1 cycle per period.
- R5: When the feedback edge leads the reference edge by k cycles, `dn` is high for k+1 cycles and `up` for 1 cycle per period.
- R6: `locked` rises one clock after the 16th consecutive reference period whose combined pulse width is at or below `width_limit`. The period that ends at the first reference edge after reset is not judged. With the first rising `ref_in` sampled at edge 0, `locked` is still 0 after edge 256 and is 1 after edge 257.
- R7: Lock is cleared by the first judged period whose width exceeds `width_limit`. The change appears one clock after the closing reference edge and never before it.
- R8: When every period's combined width exceeds `width_limit`, `locked` stays 0.
- R9: `unlock_any` equals NOT(`locked` AND `peer_locked`), both sampled one clock earlier.
- R10: `up` and `dn` are never both high for two consecutive cycles, unless both edges arrived during the clearing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Master reference clock level, halved inside |
| fb_in | input | 1 | Divided feedback clock level |
| peer_locked | input | 1 | Lock status of the companion loop |
| width_limit | input | WIDTH_W | Largest combined pulse width, in cycles, still counted as locked |
| up | output | 1 | Reference-leads correction pulse |
| dn | output | 1 | Feedback-leads correction pulse |
| locked | output | 1 | Lock flag of this loop |
| unlock_any | output | 1 | High when this loop or the companion loop is unlocked |

## Verification
Faults in the halving toggle or in the edge history show up within one reference period: an `up` pulse arrives at the wrong rate or is missing. Faults in the shared clear of the detector flops change the measured `up`/`dn` widths in the first compared period. Faults in the width accumulator or the consecutive-period counter are visible only at period boundaries. They move the cycle in which `locked` rises away from edge 257, or let it survive a period that is too wide. For that reason the bench pins both events to a single cycle.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  // Pair of correction pulses leaving the detector core.
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_pulse_t;

endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  // stg[SYNC_STAGES-1] is the newest sample, stg[SYNC_STAGES] the one before it.
  logic [SYNC_STAGES:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[SYNC_STAGES-1:0], sig_in};
  end

  assign rise = stg[SYNC_STAGES-1] & ~stg[SYNC_STAGES];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_ev,
  input  logic       fb_ev,
  output pfd_pulse_t pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= '0;
    end else if (pulse.up && pulse.dn) begin
      // Shared clear: an edge landing in this cycle starts a fresh pulse.
      pulse.up <= ref_ev;
      pulse.dn <= fb_ev;
    end else begin
      pulse.up <= pulse.up | ref_ev;
      pulse.dn <= pulse.dn | fb_ev;
    end
  end
endmodule

// File: rtl/pfd_lock_watch.sv
module pfd_lock_watch #(
  parameter int WIDTH_W      = 8,
  parameter int LOCK_PERIODS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               period_ev,
  input  logic               pulse_on,
  input  logic [WIDTH_W-1:0] width_limit,
  output logic               locked
);
  localparam int GW = $clog2(LOCK_PERIODS + 1);
  localparam logic [GW-1:0]      GOAL  = GW'(LOCK_PERIODS);
  localparam logic [WIDTH_W-1:0] W_MAX = '1;

  logic [WIDTH_W-1:0] wcnt;
  logic [WIDTH_W-1:0] total;
  logic [GW-1:0]      good;
  logic               armed;

  // Width so far, including the current cycle, saturating at the top.
  always_comb begin
    total = wcnt;
    if (pulse_on && (wcnt != W_MAX)) total = wcnt + WIDTH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      good   <= '0;
      armed  <= 1'b0;
      locked <= 1'b0;
    end else if (period_ev) begin
      wcnt  <= '0;
      armed <= 1'b1;
      if (armed) begin
        if (total <= width_limit) begin
          if (good != GOAL) good <= good + GW'(1);
          locked <= (good >= GOAL - GW'(1));
        end else begin
          good   <= '0;
          locked <= 1'b0;
        end
      end
    end else begin
      wcnt <= total;
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int WIDTH_W      = 8,
  parameter int LOCK_PERIODS = 16,
  parameter int SYNC_STAGES  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_in,
  input  logic               fb_in,
  input  logic               peer_locked,
  input  logic [WIDTH_W-1:0] width_limit,
  output logic               up,
  output logic               dn,
  output logic               locked,
  output logic               unlock_any
);
  logic       ref_rise, fb_rise, ref_half, ref_ev, lock_int;
  pfd_pulse_t pulse;

  pfd_edge_rise #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst(rst), .sig_in(ref_in), .rise(ref_rise));

  pfd_edge_rise #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst(rst), .sig_in(fb_in), .rise(fb_rise));

  // Divide-by-two of the reference: every other rising edge is compared.
  always_ff @(posedge clk) begin
    if (rst)           ref_half <= 1'b0;
    else if (ref_rise) ref_half <= ~ref_half;
  end
  assign ref_ev = ref_rise & ~ref_half;

  pfd_core u_core (
    .clk(clk), .rst(rst), .ref_ev(ref_ev), .fb_ev(fb_rise), .pulse(pulse));

  pfd_lock_watch #(.WIDTH_W(WIDTH_W), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst(rst), .period_ev(ref_ev), .pulse_on(pulse.up | pulse.dn),
    .width_limit(width_limit), .locked(lock_int));

  always_ff @(posedge clk) begin
    if (rst) unlock_any <= 1'b1;
    else     unlock_any <= ~(lock_int & peer_locked);
  end

  assign up     = pulse.up;
  assign dn     = pulse.dn;
  assign locked = lock_int;
endmodule

// File: rtl/pfd_lock_top_chk.sv
module pfd_lock_top_chk (
  input logic clk,
  input logic rst,
  input logic up,
  input logic dn,
  input logic locked,
  input logic unlock_any,
  input logic peer_locked,
  input logic ref_ev,
  input logic fb_rise
);
  // R1: reset drives the idle output state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!up && !dn && !locked && unlock_any));

  // R2: an up pulse begins only after a halved-reference edge
  p_up_from_ref_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(ref_ev));

  // R6: the lock flag moves only after a period boundary
  p_lock_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    !ref_ev |=> $stable(locked));

  // R9: merged unlock flag follows both loops one clock later
  p_merge_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (unlock_any == !($past(locked) && $past(peer_locked))));

  // R10: overlap of up and dn lasts a single cycle
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (!(up && dn) || $past(ref_ev && fb_rise)));
endmodule

bind pfd_lock_top pfd_lock_top_chk u_chk (
  .clk(clk), .rst(rst), .up(up), .dn(dn), .locked(locked),
  .unlock_any(unlock_any), .peer_locked(peer_locked),
  .ref_ev(ref_ev), .fb_rise(fb_rise));

// File: tb/pfd_lock_top_bench.sv
module pfd_lock_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic       peer_locked = 1'b1;
  logic [7:0] width_limit = 8'd1;
  logic       up, dn, locked, unlock_any;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pfd_lock_top u_pfd_lock_top (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .peer_locked(peer_locked), .width_limit(width_limit),
    .up(up), .dn(dn), .locked(locked), .unlock_any(unlock_any));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // off: feedback edge phase within the 16-cycle compared period.
  task automatic run_case(input int off, input bit first);
    int  upw = 0, dnw = 0, uprise = 0, k, lim;
    int  exp_up, exp_dn, exp_lock;
    logic upprev = 1'b0;
    lim = (off % 4) + 1;
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0; peer_locked = 1'b1;
    width_limit = 8'(lim);
    repeat (3) @(negedge clk);
    if (first) begin
      chk("R1 up", int'(up), 0);
      chk("R1 dn", int'(dn), 0);
      chk("R1 locked", int'(locked), 0);
      chk("R1 unlock_any", int'(unlock_any), 1);
    end
    rst = 1'b0;
    for (int i = 0; i < 640; i++) begin
      ref_in = ((i % 8) < 4);
      fb_in  = (((i + 16 - off) % 16) < 8);
      if (off == 0) begin
        if (i == 300) peer_locked = 1'b0;
        if (i == 310) peer_locked = 1'b1;
        if (i >= 402) width_limit = 8'd0;
      end
      @(negedge clk);
      if (i >= 314 && i <= 633) begin
        upw += int'(up);
        dnw += int'(dn);
        if (up && !upprev) uprise++;
      end
      upprev = up;
      if (off == 0) begin
        if (i == 256) chk("R6 locked before 16th period", int'(locked), 0);
        if (i == 257) chk("R6 locked after 16th period", int'(locked), 1);
        if (i == 258) chk("R9 unlock_any both locked", int'(unlock_any), 0);
        if (i == 300) chk("R9 unlock_any peer unlocked", int'(unlock_any), 1);
        if (i == 310) chk("R9 unlock_any peer relocked", int'(unlock_any), 0);
        if (i == 416) chk("R7 locked before wide period ends", int'(locked), 1);
        if (i == 417) chk("R7 locked after wide period", int'(locked), 0);
      end
    end
    if (off == 0) begin
      exp_up = 20; exp_dn = 20; k = 0;
    end else if (off <= 7) begin
      k = off; exp_up = 20 * (k + 1); exp_dn = 20;
    end else begin
      k = 16 - off; exp_up = 20; exp_dn = 20 * (k + 1);
    end
    if (off == 0)          exp_lock = 0;
    else if (k + 1 <= lim) exp_lock = 1;
    else                   exp_lock = 0;
    if (off == 0) begin
      chk($sformatf("R3 up width off=%0d", off), upw, exp_up);
      chk($sformatf("R3 dn width off=%0d", off), dnw, exp_dn);
      chk("R7 locked stays low", int'(locked), 0);
    end else if (off <= 7) begin
      chk($sformatf("R4 up width off=%0d", off), upw, exp_up);
      chk($sformatf("R4 dn width off=%0d", off), dnw, exp_dn);
    end else begin
      chk($sformatf("R5 up width off=%0d", off), upw, exp_up);
      chk($sformatf("R5 dn width off=%0d", off), dnw, exp_dn);
    end
    chk($sformatf("R2 up pulse count off=%0d", off), uprise, 20);
    if (off != 0) begin
      if (exp_lock == 1)
        chk($sformatf("R6 locked off=%0d lim=%0d", off, lim), int'(locked), 1);
      else
        chk($sformatf("R8 locked off=%0d lim=%0d", off, lim), int'(locked), 0);
      chk($sformatf("R9 unlock_any off=%0d", off), int'(unlock_any), 1 - exp_lock);
    end
  endtask

  initial begin
    for (int off = 0; off < 16; off++) begin
      if (off != 8) run_case(off, off == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule